// File: doc/BRIEF.md
# Double-Sided PWM Serializer for a Multi-Level Quantizer

This block sits between a flash quantizer and the gate drivers of a two-level H-bridge. Once per sample period it captures a thermometer code and turns it into a frame of SLOTS serial bits, one bit per fast-clock cycle. The number of high bits in the frame equals the quantizer level, so each frame's average is a time-quantized duty cycle. With the default of 20 bits per frame, an 80 MHz bit clock gives a 4 MHz sample rate.

Two ordering modes are supported. Single-sided frames always put the high bits first. Double-sided frames reverse the order on every frame, so adjacent frames share a plateau. This halves the carrier and the number of switching edges. A sparse level set can also be selected. It drops the two levels next to each rail and expands the two outermost comparator inputs into blocks of PAD_BITS bits each. No high or low run can then be shorter than PAD_BITS bit clocks. The block drives two complementary outputs, one for each half-bridge, which switch in anti-phase.

Top module: `dspwm_serializer`

## Requirements
- R1: A frame is SLOTS (default 20) bit clocks long. A strobe sampled on a clock edge starts a new frame at bit 0. Bit j of that frame appears on `drive_p` after the (j+1)-th edge following the strobe edge. If no strobe arrives, the frame repeats every SLOTS edges with the held level and the held modes.
- R2: Each frame holds exactly `level` high bits. In uniform level mode (`nonuniform`=0), `level` is the number of set bits in `therm_code`, from 0 to SLOTS.
- R3: In single-sided mode (`double_sided`=0), frame bit j is high exactly when j < level, so high bits come first.
- R4: In double-sided mode (`double_sided`=1), every frame start reverses the order of the previous frame. A zeros-first frame has bit j high exactly when j >= SLOTS-level. After a single-sided frame, the next frame is zeros-first. With a constant mid-scale level, double-sided mode makes half as many output edges per frame as single-sided mode.
- R5: In sparse level mode (`nonuniform`=1), only the lowest SLOTS-2*(PAD_BITS-1) bits of `therm_code` are counted (16 by default). A count of t maps to level 0 if t=0, to SLOTS if every counted bit is set, and to t+PAD_BITS-1 otherwise. On a stream made only of sparse frames, every high or low run is at least PAD_BITS (3) bits long.
- R6: `drive_n` is always the complement of `drive_p`. During reset, and until the first strobe, `drive_p`=0 and `drive_n`=1.
- R7: `therm_code`, `double_sided` and `nonuniform` have no effect on any cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sample_strobe | input | 1 | Captures the code and the modes and starts a frame |
| therm_code | input | SLOTS | Thermometer code from the comparator bank |
| double_sided | input | 1 | 1: alternate the order every frame, 0: high bits first |
| nonuniform | input | 1 | 1: sparse level set with padded outer comparators |
| drive_p | output | 1 | Serial PWM bit for the positive half-bridge |
| drive_n | output | 1 | Complement of drive_p for the negative half-bridge |

## Verification
The bench builds the block with its defaults: SLOTS=20 and PAD_BITS=3. These put every uniform level from 0 to 20 and every sparse count from 0 to 16 within reach of random frames. They also expose the 3-bit minimum run at the sparse levels 3 and 17, right next to the removed levels. Because a frame is 20 bits long, an 8-frame window of mid-scale code gives exact edge totals of 16 in single-sided mode and 8 in double-sided mode. Directed segments cover frames that repeat without a strobe and mode inputs that toggle mid-frame.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

    typedef enum logic {
        ORDER_ONES_FIRST  = 1'b0,
        ORDER_ZEROS_FIRST = 1'b1
    } order_e;

    typedef enum logic {
        CARRIER_SINGLE = 1'b0,
        CARRIER_DOUBLE = 1'b1
    } carrier_e;

    typedef enum logic {
        LEVELS_UNIFORM = 1'b0,
        LEVELS_SPARSE  = 1'b1
    } levelset_e;

    typedef struct packed {
        carrier_e  carrier;
        levelset_e levels;
        order_e    order;
    } frame_mode_t;

    // Order used by a frame that is starting, given the carrier in force for it.
    function automatic order_e next_order(carrier_e carrier, order_e prev);
        if (carrier == CARRIER_DOUBLE) begin
            return (prev == ORDER_ONES_FIRST) ? ORDER_ZEROS_FIRST : ORDER_ONES_FIRST;
        end
        return ORDER_ONES_FIRST;
    endfunction

endpackage

// File: rtl/dspwm_level_map.sv
module dspwm_level_map
    import dspwm_pkg::*;
#(
    parameter  int SLOTS    = 20,
    parameter  int PAD_BITS = 3,
    localparam int LW       = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] therm,
    input  levelset_e        levels,
    output logic [LW-1:0]    level
);
    localparam int INNER = SLOTS - 2 * (PAD_BITS - 1);

    logic [LW-1:0] full_cnt;
    logic [LW-1:0] inner_cnt;

    always_comb begin
        full_cnt  = '0;
        inner_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            full_cnt = full_cnt + LW'(therm[i]);
            if (i < INNER) begin
                inner_cnt = inner_cnt + LW'(therm[i]);
            end
        end
    end

    always_comb begin
        if (levels == LEVELS_UNIFORM) begin
            level = full_cnt;
        end else if (inner_cnt == '0) begin
            level = '0;
        end else if (inner_cnt == LW'(INNER)) begin
            level = LW'(SLOTS);
        end else begin
            level = inner_cnt + LW'(PAD_BITS - 1);
        end
    end

endmodule

// File: rtl/dspwm_frame_ctrl.sv
module dspwm_frame_ctrl
    import dspwm_pkg::*;
#(
    parameter  int SLOTS    = 20,
    parameter  int PAD_BITS = 3,
    localparam int LW       = $clog2(SLOTS + 1),
    localparam int CNTW     = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [LW-1:0] level_in,
    input  carrier_e      carrier_in,
    input  levelset_e     levels_in,
    output logic [CNTW-1:0] cnt,
    output logic [LW-1:0] level_q,
    output frame_mode_t   mode_q
);
    localparam logic [CNTW-1:0] LAST = CNTW'(SLOTS - 1);

    logic     frame_start;
    carrier_e carrier_next;

    assign frame_start  = strobe || (cnt == LAST);
    assign carrier_next = strobe ? carrier_in : mode_q.carrier;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            level_q <= '0;
            mode_q  <= '{carrier: CARRIER_SINGLE, levels: LEVELS_UNIFORM, order: ORDER_ONES_FIRST};
        end else if (frame_start) begin
            cnt          <= '0;
            mode_q.order <= next_order(carrier_next, mode_q.order);
            if (strobe) begin
                level_q        <= level_in;
                mode_q.carrier <= carrier_in;
                mode_q.levels  <= levels_in;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                                           // R1
    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (cnt == '0));                                                // R1
    AST_WRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!strobe && cnt == LAST) |=> (cnt == '0) && $stable(level_q)
                                     && $stable(mode_q.carrier) && $stable(mode_q.levels)); // R1
    AST_MIDFRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!strobe && cnt != LAST) |=> $stable(level_q) && $stable(mode_q));      // R7
    AST_SS_ONES_FIRST: assert property (@(posedge clk) disable iff (rst)
        (mode_q.carrier == CARRIER_SINGLE) |-> (mode_q.order == ORDER_ONES_FIRST)); // R3
    AST_DS_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (!strobe && cnt == LAST && mode_q.carrier == CARRIER_DOUBLE)
            |=> (mode_q.order != $past(mode_q.order)));                         // R4
    AST_SPARSE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (mode_q.levels == LEVELS_SPARSE) |-> (level_q == '0 || level_q == LW'(SLOTS)
            || (level_q >= LW'(PAD_BITS) && level_q <= LW'(SLOTS - PAD_BITS)))); // R5

endmodule

// File: rtl/dspwm_bit_gen.sv
module dspwm_bit_gen
    import dspwm_pkg::*;
#(
    parameter  int SLOTS = 20,
    localparam int LW    = $clog2(SLOTS + 1),
    localparam int CNTW  = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CNTW-1:0] cnt,
    input  logic [LW-1:0]   level,
    input  order_e          order,
    output logic            drive_hi,
    output logic            drive_lo
);
    logic bit_now;

    always_comb begin
        if (order == ORDER_ONES_FIRST) begin
            bit_now = (LW'(cnt) < level);
        end else begin
            bit_now = (LW'(cnt) >= (LW'(SLOTS) - level));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_hi <= 1'b0;
            drive_lo <= 1'b1;
        end else begin
            drive_hi <= bit_now;
            drive_lo <= ~bit_now;
        end
    end

    // Frame weight tracking, used only by the check below.
    logic [LW:0] weight_q;
    logic [LW:0] weight_base;

    assign weight_base = (cnt == '0) ? '0 : weight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            weight_q <= '0;
        end else begin
            weight_q <= weight_base + (LW+1)'(bit_now);
        end
    end

    AST_FRAME_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNTW'(SLOTS - 1)) |-> (weight_base + (LW+1)'(bit_now) == (LW+1)'(level))); // R2
    AST_ANTI_PHASE: assert property (@(posedge clk) disable iff (rst)
        drive_hi != drive_lo);                                                  // R6

endmodule

// File: rtl/dspwm_serializer.sv
module dspwm_serializer
    import dspwm_pkg::*;
#(
    parameter int SLOTS    = 20,
    parameter int PAD_BITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_strobe,
    input  logic [SLOTS-1:0] therm_code,
    input  logic             double_sided,
    input  logic             nonuniform,
    output logic             drive_p,
    output logic             drive_n
);
    localparam int LW   = $clog2(SLOTS + 1);
    localparam int CNTW = $clog2(SLOTS);

    levelset_e       levels_in;
    carrier_e        carrier_in;
    logic [LW-1:0]   level_in;
    logic [CNTW-1:0] cnt;
    logic [LW-1:0]   level_q;
    frame_mode_t     mode_q;

    assign levels_in  = nonuniform   ? LEVELS_SPARSE  : LEVELS_UNIFORM;
    assign carrier_in = double_sided ? CARRIER_DOUBLE : CARRIER_SINGLE;

    dspwm_level_map #(.SLOTS(SLOTS), .PAD_BITS(PAD_BITS)) i_level_map (
        .therm  (therm_code),
        .levels (levels_in),
        .level  (level_in)
    );

    dspwm_frame_ctrl #(.SLOTS(SLOTS), .PAD_BITS(PAD_BITS)) i_frame_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strobe     (sample_strobe),
        .level_in   (level_in),
        .carrier_in (carrier_in),
        .levels_in  (levels_in),
        .cnt        (cnt),
        .level_q    (level_q),
        .mode_q     (mode_q)
    );

    dspwm_bit_gen #(.SLOTS(SLOTS)) i_bit_gen (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .level    (level_q),
        .order    (mode_q.order),
        .drive_hi (drive_p),
        .drive_lo (drive_n)
    );

endmodule

// File: tb/test_dspwm_serializer.sv
module test_dspwm_serializer;

    localparam int SL    = 20;
    localparam int PADB  = 3;
    localparam int INNER = SL - 2 * (PADB - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_strobe = 1'b0;
    logic [SL-1:0] therm_code = '0;
    logic          double_sided = 1'b0;
    logic          nonuniform = 1'b0;
    logic          drive_p;
    logic          drive_n;

    always #2.5 clk = ~clk;

    dspwm_serializer #(.SLOTS(SL), .PAD_BITS(PADB)) i_dspwm_serializer (
        .clk           (clk),
        .rst           (rst),
        .sample_strobe (sample_strobe),
        .therm_code    (therm_code),
        .double_sided  (double_sided),
        .nonuniform    (nonuniform),
        .drive_p       (drive_p),
        .drive_n       (drive_n)
    );

    int checks = 0;
    int errors = 0;

    // Bench model state, derived from the requirements.
    int   m_cnt = 0, m_k = 0, m_fid = 0;
    logic m_zf = 1'b0, m_ds = 1'b0;
    // Expectation pending for the next observation.
    logic pend_valid = 1'b0, pend_bit = 1'b0, pend_zf = 1'b0;
    int   pend_j = 0, pend_k = 0, pend_fid = 0;
    string cur_tag = "";
    // Observation trackers.
    int   obs_ones = 0;
    logic have_prev = 1'b0, prev_bit = 1'b0;
    int   win_lo = 1 << 30, win_hi = 1 << 30, win_edges = 0;
    int   run_lo = 1 << 30, runlen = 0;
    logic run_valid = 1'b0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    function automatic int exp_level(logic [SL-1:0] th, logic nu);
        int c = 0;
        if (!nu) begin
            for (int i = 0; i < SL; i++) c += int'(th[i]);
            return c;
        end
        for (int i = 0; i < INNER; i++) c += int'(th[i]);
        if (c == 0) return 0;
        if (c == INNER) return SL;
        return c + PADB - 1;
    endfunction

    function automatic logic [SL-1:0] therm_of(int n, logic [SL-1:0] upper_junk, logic nu);
        logic [SL-1:0] t = '0;
        for (int i = 0; i < SL; i++) begin
            if (i < n) t[i] = 1'b1;
            else if (nu && i >= INNER) t[i] = upper_junk[i];
        end
        return t;
    endfunction

    task automatic observe();
        string tag;
        if (!pend_valid) return;
        tag = (cur_tag != "") ? cur_tag : (pend_zf ? "R4" : "R3");
        check(drive_p === pend_bit, tag, int'(drive_p), int'(pend_bit));
        check(drive_n === ~drive_p, "R6", int'(drive_n), int'(~drive_p));
        if (pend_j == 0) obs_ones = 0;
        obs_ones += int'(drive_p);
        if (pend_j == SL - 1) check(obs_ones == pend_k, "R2", obs_ones, pend_k);
        if (have_prev && drive_p != prev_bit && pend_fid >= win_lo && pend_fid <= win_hi)
            win_edges++;
        if (pend_fid < run_lo) begin
            run_valid = 1'b0;
        end else if (have_prev && drive_p != prev_bit) begin
            if (run_valid) check(runlen >= PADB, "R5", runlen, PADB);
            runlen = 1;
            run_valid = 1'b1;
        end else begin
            runlen++;
        end
        prev_bit  = drive_p;
        have_prev = 1'b1;
    endtask

    task automatic step(input logic stb, input logic [SL-1:0] th, input logic ds, input logic nu);
        logic eff;
        @(negedge clk);
        observe();
        rst = 1'b0;
        sample_strobe = stb;
        therm_code = th;
        double_sided = ds;
        nonuniform = nu;
        pend_bit = m_zf ? (m_cnt >= SL - m_k) : (m_cnt < m_k);
        pend_zf = m_zf;
        pend_j = m_cnt;
        pend_k = m_k;
        pend_fid = m_fid;
        pend_valid = 1'b1;
        if (stb || m_cnt == SL - 1) begin
            eff = stb ? ds : m_ds;
            m_zf = eff ? ~m_zf : 1'b0;
            if (stb) begin
                m_k = exp_level(th, nu);
                m_ds = ds;
            end
            m_cnt = 0;
            m_fid++;
        end else begin
            m_cnt++;
        end
    endtask

    // One frame: strobe (optional) on bit 0, then either held or garbage inputs.
    task automatic frame(input logic stb, input logic [SL-1:0] th, input logic ds,
                         input logic nu, input logic garbage);
        for (int j = 0; j < SL; j++) begin
            if (j == 0) step(stb, th, ds, nu);
            else if (garbage) step(1'b0, SL'($urandom), 1'($urandom), 1'($urandom));
            else step(1'b0, th, ds, nu);
        end
    endtask

    task automatic random_frame(input logic nu_only, input logic garbage);
        logic nu = nu_only ? 1'b1 : 1'($urandom);
        logic ds = 1'($urandom);
        int   n = nu ? int'($urandom_range(INNER, 0)) : int'($urandom_range(SL, 0));
        frame(1'b1, therm_of(n, SL'($urandom), nu), ds, nu, garbage);
    endtask

    task automatic edge_segment(input logic ds, output int edges);
        win_lo = m_fid + 2;
        win_hi = win_lo + 7;
        win_edges = 0;
        frame(1'b1, therm_of(SL / 2, '0, 1'b0), ds, 1'b0, 1'b0);
        for (int f = 0; f < 9; f++) frame(1'b0, '0, ds, 1'b0, 1'b0);
        edges = win_edges;
        win_lo = 1 << 30;
        win_hi = 1 << 30;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int e_ss, e_ds;
        void'($urandom(32'd2024));

        // Reset state: R6
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(drive_p === 1'b0, "R6", int'(drive_p), 0);
        check(drive_n === 1'b1, "R6", int'(drive_n), 1);

        // Idle frames before any strobe keep the output low: R6
        cur_tag = "R6";
        for (int f = 0; f < 2; f++) frame(1'b0, '1, 1'b1, 1'b0, 1'b0);
        cur_tag = "";

        // Directed uniform corners in both orderings: R2 R3 R4
        for (int d = 0; d < 2; d++) begin
            frame(1'b1, therm_of(0,  '0, 1'b0), 1'(d), 1'b0, 1'b0);
            frame(1'b1, therm_of(SL, '0, 1'b0), 1'(d), 1'b0, 1'b0);
            frame(1'b1, therm_of(1,  '0, 1'b0), 1'(d), 1'b0, 1'b0);
            frame(1'b1, therm_of(SL - 1, '0, 1'b0), 1'(d), 1'b0, 1'b0);
        end

        // Mixed random frames
        for (int f = 0; f < 60; f++) random_frame(1'b0, 1'b0);

        // Edge rate with a mid-scale code: R4
        edge_segment(1'b0, e_ss);
        edge_segment(1'b1, e_ds);
        check(e_ss == 16, "R4", e_ss, 16);
        check(e_ds == 8, "R4", e_ds, 8);
        check(e_ss == 2 * e_ds, "R4", e_ss, 2 * e_ds);

        // Frames repeating without a strobe: R1
        cur_tag = "R1";
        frame(1'b1, therm_of(7, '0, 1'b0), 1'b1, 1'b0, 1'b0);
        for (int f = 0; f < 3; f++) frame(1'b0, therm_of(2, '0, 1'b0), 1'b0, 1'b0, 1'b0);
        frame(1'b1, therm_of(13, '0, 1'b0), 1'b0, 1'b0, 1'b0);
        frame(1'b0, '0, 1'b1, 1'b1, 1'b0);

        // Inputs toggling between strobes: R7
        cur_tag = "R7";
        for (int f = 0; f < 12; f++) random_frame(1'b0, 1'b1);

        // Sparse level set, minimum run length and mapping: R5
        cur_tag = "R5";
        frame(1'b1, therm_of(0, '0, 1'b1), 1'b0, 1'b1, 1'b0);
        run_lo = m_fid + 1;
        frame(1'b1, therm_of(1, '1, 1'b1), 1'b0, 1'b1, 1'b0);
        frame(1'b1, therm_of(INNER - 1, '1, 1'b1), 1'b0, 1'b1, 1'b0);
        frame(1'b1, therm_of(1, '0, 1'b1), 1'b1, 1'b1, 1'b0);
        frame(1'b1, therm_of(INNER - 1, '0, 1'b1), 1'b1, 1'b1, 1'b0);
        frame(1'b1, therm_of(INNER, '1, 1'b1), 1'b1, 1'b1, 1'b0);
        frame(1'b1, therm_of(1, '0, 1'b1), 1'b1, 1'b1, 1'b0);
        for (int f = 0; f < 50; f++) random_frame(1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        cur_tag = "";

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule